// File: doc/BRIEF.md
# Masked Sample-Matrix Copier

After an acquisition ends, this sequencer moves digitized samples out of a four-channel sampling matrix into a linear sample RAM. The matrix is read as a grid of columns by channels. The copier takes the columns in rising order, starting at column 0. Inside each column it writes the enabled channels in rising channel index, one RAM word per clock cycle.

Two values limit how much is copied. A column count sets how many columns are transferred, and a channel mask removes unused channels. The remaining words are packed with no gaps at RAM addresses 0, 1, 2 and so on. The address counter is internal and restarts at zero for every copy.

A start strobe launches a copy. A busy flag is high while writes are in progress, and a one-cycle done pulse follows the last write. If sync was enabled when the copy started, a sync output marks the cycle in which the scan enters the start of the matrix.

Top module: `mcopy_top`

## Requirements
- R1: After reset, busy, ram_we, done and sync_out are all 0.
- R2: A start strobe is taken only while the copier is idle. A start seen while busy is ignored, so the write stream that is under way is not changed.
- R3: Writes go by column, rising from 0. Inside a column they go by enabled channel index, rising. There is one write per cycle. mat_col and mat_chan give the matrix cell being written, and ram_wdata = {3'b000, mat_data} in the same cycle. In mat_data, bit 12 flags overflow and bits 11:0 hold the sample.
- R4: The first write of every copy goes to ram_addr 0. Each following write goes to the previous address plus one.
- R5: Channel i is written only when bit i of chan_mask is 1. A masked channel is skipped and uses no address.
- R6: Exactly col_count columns are copied. A col_count of 0, or of more than 128, copies all 128 columns.
- R7: done is high for one cycle, in the cycle after the last write, and busy is 0 in that cycle. A start taken with n writes to do gives done n+1 cycles after the start edge.
- R8: A start with chan_mask = 0 makes no RAM writes and pulses done in the cycle after the start edge.
- R9: sync_out is high only in the write cycle of ram_addr 0, and only when sync_en was 1 at start. It is 0 in every other cycle.
- R10: col_count, chan_mask and sync_en are sampled at the start edge. Changing them during a copy has no effect on that copy.
- R11: A start presented in the cycle in which done is high is taken. The new copy begins in the next cycle at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a copy when idle |
| col_count | input | 8 | Number of columns to copy (0 or >128 means 128) |
| chan_mask | input | 4 | Per-channel enable, bit i enables channel i |
| sync_en | input | 1 | Enables the start-of-matrix sync output |
| mat_col | output | 7 | Matrix column being read |
| mat_chan | output | 2 | Matrix channel being read |
| mat_data | input | 13 | Sample read from the matrix at mat_col/mat_chan |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the last write |
| sync_out | output | 1 | Marks the write at the start of the matrix |

## Verification
The done pulse that ends one copy can fall in the same cycle as the start strobe that launches the next. The bench provokes this by raising start at the very moment it sees done high. It then requires the second copy to begin on the next edge at address 0, with sync_out on its first write. The sync pulse also shares its cycle with the first RAM write. For each scored write the bench checks sync_out together with the address, column, channel and data, and it checks that sync_out is 0 in every cycle with no write. A start strobe landing mid-copy, with the settings changed at the same time, is judged by the write stream staying exactly as predicted.

// File: rtl/mcopy_pkg.sv
// Package: shared helpers for the sample-matrix copier.
// Assumes: column counts are given as plain integers.
package mcopy_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mcopy_state_t;

    // Maps a requested column count to the number of columns really copied.
    function automatic int eff_cols(input int req, input int ncol);
        return ((req == 0) || (req > ncol)) ? ncol : req;
    endfunction

endpackage

// File: rtl/mcopy_chan_pick.sv
// Module: finds the lowest set bit of a channel mask at or above a start index.
// Assumes: NCHAN is a power of two. A start index of NCHAN or more finds nothing.
module mcopy_chan_pick #(
    parameter int NCHAN = 4,
    localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic [NCHAN-1:0] mask,
    input  logic [CW:0]      from,
    output logic             found,
    output logic [CW-1:0]    idx
);

    // Priority search, scanning downward so the lowest qualifying index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCHAN - 1; i >= 0; i--) begin
            if (mask[i] && ((CW+1)'(i) >= from)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/mcopy_loop_ctl.sv
// Module: column and channel loops of the copier, plus the done pulse.
// Assumes: one RAM write per cycle while busy. Settings are latched on a
// start that is taken. A start while running is ignored.
module mcopy_loop_ctl #(
    parameter int NCHAN = 4,
    parameter int NCOL  = 128,
    localparam int CW   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int COLW = $clog2(NCOL),
    localparam int CCW  = $clog2(NCOL) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CCW-1:0]   col_count,
    input  logic [NCHAN-1:0] chan_mask,
    input  logic             sync_en,
    output logic             busy,
    output logic             done,
    output logic             start_acc,
    output logic [COLW-1:0]  col,
    output logic [CW-1:0]    chan,
    output logic             sync_en_q
);
    import mcopy_pkg::*;

    mcopy_state_t     state;
    logic [NCHAN-1:0] mask_q;
    logic [CCW-1:0]   cols_q;
    logic [CW-1:0]    first_q;
    logic             first_found, next_found;
    logic [CW-1:0]    first_idx, next_idx;
    logic [CW:0]      next_from;
    logic             last_col;

    // Lowest enabled channel of the incoming mask, used when a start is taken.
    mcopy_chan_pick #(.NCHAN(NCHAN)) u_first (
        .mask  (chan_mask),
        .from  ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    // Next enabled channel above the current one, within the latched mask.
    mcopy_chan_pick #(.NCHAN(NCHAN)) u_next (
        .mask  (mask_q),
        .from  (next_from),
        .found (next_found),
        .idx   (next_idx)
    );

    // Search start index and last-column detect.
    always_comb begin
        next_from = {1'b0, chan} + 1'b1;
        last_col  = ({1'b0, col} == (cols_q - 1'b1));
        busy      = (state == ST_RUN);
        start_acc = (state == ST_IDLE) && start && first_found;
    end

    // Main sequencer: start acceptance, channel stepping, column stepping, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            col       <= '0;
            chan      <= '0;
            mask_q    <= '0;
            cols_q    <= '0;
            first_q   <= '0;
            sync_en_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    if (first_found) begin
                        state     <= ST_RUN;
                        col       <= '0;
                        chan      <= first_idx;
                        first_q   <= first_idx;
                        mask_q    <= chan_mask;
                        cols_q    <= CCW'(eff_cols(int'(col_count), NCOL));
                        sync_en_q <= sync_en;
                    end else begin
                        done <= 1'b1;
                    end
                end
            end else begin
                if (next_found) begin
                    chan <= next_idx;
                end else if (last_col) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    col  <= col + 1'b1;
                    chan <= first_q;
                end
            end
        end
    end

    // R5
    mask_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mask_q[chan]);

    // R6
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, col} < cols_q));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (col != $past(col))) |-> (col == $past(col) + 1'b1));

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/mcopy_addr_gen.sv
// Module: RAM write address counter for the copier.
// Assumes: it is cleared on every start that is taken, and it advances once
// per busy cycle, since every busy cycle is a write.
module mcopy_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr
);

    // Clear to zero at start, count up on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(step)) |-> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/mcopy_top.sv
// Module: top of the masked sample-matrix to RAM copier.
// Assumes: the matrix returns mat_data in the same cycle as mat_col/mat_chan,
// and the RAM accepts one write per cycle without back-pressure.
module mcopy_top #(
    parameter int NCHAN = 4,
    parameter int NCOL  = 128,
    parameter int DW    = 13,
    parameter int AW    = 16,
    parameter int RW    = 16,
    localparam int CW   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int COLW = $clog2(NCOL),
    localparam int CCW  = $clog2(NCOL) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CCW-1:0]   col_count,
    input  logic [NCHAN-1:0] chan_mask,
    input  logic             sync_en,
    output logic [COLW-1:0]  mat_col,
    output logic [CW-1:0]    mat_chan,
    input  logic [DW-1:0]    mat_data,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [RW-1:0]    ram_wdata,
    output logic             busy,
    output logic             done,
    output logic             sync_out
);

    logic            start_acc;
    logic            sync_en_q;
    logic [COLW-1:0] col;
    logic [CW-1:0]   chan;
    logic [AW-1:0]   addr;

    // Loop sequencer.
    mcopy_loop_ctl #(.NCHAN(NCHAN), .NCOL(NCOL)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .col_count (col_count),
        .chan_mask (chan_mask),
        .sync_en   (sync_en),
        .busy      (busy),
        .done      (done),
        .start_acc (start_acc),
        .col       (col),
        .chan      (chan),
        .sync_en_q (sync_en_q)
    );

    // Write address counter.
    mcopy_addr_gen #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_acc),
        .step  (busy),
        .addr  (addr)
    );

    // Matrix read address, RAM write port and start-of-matrix sync.
    always_comb begin
        mat_col   = col;
        mat_chan  = chan;
        ram_we    = busy;
        ram_addr  = addr;
        ram_wdata = {{(RW-DW){1'b0}}, mat_data};
        sync_out  = sync_en_q && busy && (col == '0) && (addr == '0);
    end

    // R9
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_we && !sync_out));

endmodule

// File: tb/tb_mcopy_top.sv
module tb_mcopy_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  col_count = '0;
    logic [3:0]  chan_mask = '0;
    logic        sync_en = 1'b0;
    logic [6:0]  mat_col;
    logic [1:0]  mat_chan;
    logic [12:0] mat_data;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [15:0] ram_wdata;
    logic        busy, done, sync_out;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    typedef struct packed {
        logic [15:0] addr;
        logic [6:0]  col;
        logic [1:0]  chan;
        logic        sync;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    mcopy_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .col_count(col_count),
        .chan_mask(chan_mask), .sync_en(sync_en), .mat_col(mat_col),
        .mat_chan(mat_chan), .mat_data(mat_data), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy),
        .done(done), .sync_out(sync_out)
    );

    function automatic logic [12:0] smp(input int c, input int h);
        return 13'((c * 37 + h * 1000 + 5) % 8192);
    endfunction

    // Matrix model: combinational sample per cell.
    assign mat_data = smp(int'(mat_col), int'(mat_chan));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected writes and compares them with the design output.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (ram_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write addr", ram_addr, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(ram_addr == e.addr, "R4", "ram_addr", ram_addr, e.addr);
                    chk(mat_col == e.col, "R3", "mat_col", mat_col, e.col);
                    chk(mat_chan == e.chan, "R3", "mat_chan", mat_chan, e.chan);
                    chk(ram_wdata == {3'b000, smp(e.col, e.chan)}, "R3", "ram_wdata",
                        ram_wdata, {3'b000, smp(e.col, e.chan)});
                    chk(sync_out == e.sync, "R9", "sync_out", sync_out, e.sync);
                end
            end else if (sync_out) begin
                chk(1'b0, "R9", "sync_out without write", 1, 0);
            end
        end
    end

    // Driver: pushes the expected stream, strobes start, waits for done.
    // Called at a negedge; returns at the negedge where done is seen.
    task automatic copy(input int cols, input logic [3:0] mask, input bit sen,
                        input bit disturb, input string req);
        int eff, n, cnt;
        eff = (cols == 0 || cols > 128) ? 128 : cols;
        n = 0;
        if (mask != 0) begin
            for (int c = 0; c < eff; c++) begin
                for (int h = 0; h < 4; h++) begin
                    if (mask[h]) begin
                        exp_q.push_back('{addr: 16'(n), col: 7'(c), chan: 2'(h),
                                          sync: (sen && n == 0)});
                        n++;
                    end
                end
            end
        end
        col_count = 8'(cols);
        chan_mask = mask;
        sync_en   = sen;
        start     = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
            if (disturb && cnt == 2) begin
                // R2 / R10: start and new settings in mid-copy must be ignored
                start     = 1'b1;
                chan_mask = ~mask;
                col_count = 8'd1;
                sync_en   = ~sen;
            end
        end while (!done && cnt < 2000);
        start = 1'b0;
        chk(done == 1'b1, "R7", {req, " done seen"}, done, 1);
        chk(cnt == n + 1, "R7", {req, " done latency"}, cnt, n + 1);
        chk(busy == 1'b0, "R7", {req, " busy at done"}, busy, 0);
        chk(exp_q.size() == 0, "R6", {req, " writes left unmade"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(ram_we == 1'b0, "R1", "ram_we after reset", ram_we, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(sync_out == 1'b0, "R1", "sync_out after reset", sync_out, 0);
        mon_on = 1'b1;
        idle(2);
        // R6: zero count means full matrix, all channels, sync on (R9)
        copy(0, 4'b1111, 1'b1, 1'b0, "R6 full");
        idle(3);
        // R5: sparse mask, short count, sync off
        copy(5, 4'b1010, 1'b0, 1'b0, "R5 mask1010");
        idle(2);
        // R2 / R10: disturbance during copy
        copy(3, 4'b1001, 1'b1, 1'b1, "R10 disturb");
        chan_mask = 4'b0000;
        idle(1);
        chk(ram_we == 1'b0, "R2", "no write after ignored start", ram_we, 0);
        idle(2);
        // R8: empty mask
        copy(7, 4'b0000, 1'b1, 1'b0, "R8 empty mask");
        idle(2);
        // R6: count above 128 clamps
        copy(200, 4'b0100, 1'b1, 1'b0, "R6 clamp");
        idle(2);
        // R11: back-to-back, second start in the done cycle
        copy(2, 4'b0011, 1'b0, 1'b0, "R11 first");
        copy(1, 4'b1000, 1'b1, 1'b0, "R11 second");
        idle(3);
        chk(busy == 1'b0, "R7", "idle at end", busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule